// File: doc/BRIEF.md
# MAC and VLAN Table Search Engine

This block serves add, delete and lookup requests against a forwarding table that lives outside it. A client presents a 48-bit MAC address and a 12-bit VLAN ID, or a VLAN ID alone, and pulses `start`. The engine reads the table one entry at a time through a synchronous read port with one cycle of latency. It visits the indices in ascending order. It reports whether a hit was found, where it was found, and which kind of hit it was.

For an insert the engine picks the target slot by priority. An entry that already holds the same key wins. Failing that, the lowest free entry is used. Failing that, the lowest entry that may be aged out is overwritten. The free and ageable candidates are gathered during the single pass. Once a slot is chosen, the engine writes the client's prepared entry into it through a write port for exactly one cycle. If no slot qualifies, the insert fails and nothing is written.

Entry layout that the engine decodes (all other bits are carried but not inspected):
- type, bits 61:60: 0 free, 1 address, 2 VLAN, 3 VLAN+address
- VLAN ID, bits 59:48
- MAC, bits 47:0, with the first byte at 47:40 and the last byte at 7:0
- multicast flag, bit 40
- unicast kind, bits 63:62: 0 persistent, 1 untouched, 2 OUI, 3 touched

FSM states:
- `S_IDLE`: waits for `start`. On `start` it latches the request → `S_FETCH`.
- `S_FETCH`: issues a read of the current index → `S_EVAL`.
- `S_EVAL`: classifies the returned entry.
  - On a key hit → `S_WRITE` for an insert, `S_FINISH` otherwise.
  - At the last index → `S_WRITE` if an insert has a free or ageable candidate, `S_FINISH` otherwise.
  - Otherwise it advances the index → `S_FETCH`.
- `S_WRITE`: writes the entry → `S_FINISH`.
- `S_FINISH`: pulses `done` → `S_IDLE`.

Top module: `tsearch_engine`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en`, `rd_en` and `found` are all 0.
- R2: An address search hits an entry only when all three hold: the entry type is 1 or 3, bits 59:48 equal the search VID, and bits 47:0 equal the MAC. VLAN entries (type 2) never hit an address search, even when their low bits equal the MAC.
- R3: When `use_vlan` is 0, the address search uses VID 0 and ignores the `vid` input.
- R4: A VLAN search (`op` = 2) hits only entries of type 2 whose bits 59:48 equal `vid`.
- R5: Indices are scanned in ascending order, and a lookup reports the lowest hit.
  - For a hit at index i, `done` rises 2+2i clock edges after the edge that captured `start`.
  - For a lookup with no hit, `done` rises after 2·DEPTH edges.
- R6: An insert (`op` = 1) chooses its slot in this order, and `kind` reports the choice:
  - an existing address hit, `kind` 1;
  - else the lowest free entry (type 0), `kind` 2;
  - else the lowest ageable entry, `kind` 3. An ageable entry has type 1 or 3, bit 40 = 0, and bits 63:62 equal to 1 or 3.
- R7: A successful insert writes `new_entry` unchanged at the chosen index with exactly one `wr_en` cycle, in the cycle before `done`.
  - With an existing hit at i, `done` rises after 3+2i edges.
  - With a free or ageable slot, `done` rises after 2·DEPTH+1 edges.
- R8: An insert with no hit, no free entry and no ageable entry writes nothing. It ends with `found` = 0 and `kind` 0 after 2·DEPTH edges.
- R9: `start` is ignored while `busy` is 1.
- R10: `done` is a single-cycle pulse. `found`, `index` and `kind` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted in `S_IDLE` |
| op | input | 2 | 0 address lookup, 1 address insert, 2 VLAN lookup |
| use_vlan | input | 1 | Qualify the address search by `vid`; when 0 the search uses VID 0 |
| vid | input | 12 | VLAN ID of the request |
| mac | input | 48 | MAC address of the request |
| new_entry | input | ENTRY_W | Entry written on a successful insert |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A hit or slot was found |
| index | output | IDX_W | Index of the hit or chosen slot |
| kind | output | 2 | 0 none, 1 key hit, 2 free slot, 3 ageable slot |
| rd_en | output | 1 | Table read request |
| rd_addr | output | IDX_W | Table read index |
| rd_data | input | ENTRY_W | Table read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | IDX_W | Table write index |
| wr_data | output | ENTRY_W | Table write data |

## Verification
Every result is due a fixed number of edges after the edge that captures `start`:
- 2+2i for a lookup hit at index i;
- 3+2i for an insert that hits at index i;
- 2·DEPTH+1 for an insert into a free or ageable slot;
- 2·DEPTH for any miss.

The bench counts edges from the capture edge and samples `done` and the results on falling edges. It compares the count with these formulas, so an off-by-one in the scan or an extra state shows up as a latency failure. Table writes are checked after the finishing edge, by reading the bench's own table model and a count of `wr_en` cycles.

// File: rtl/tsearch_pkg.sv
package tsearch_pkg;

    localparam int MAC_W    = 48;
    localparam int VID_W    = 12;
    localparam int KEY_W    = 64;
    localparam int VID_LO   = 48;
    localparam int TYPE_LO  = 60;
    localparam int UKIND_LO = 62;
    localparam int MCAST_B  = 40;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_MATCH = 2'd1,
        K_FREE  = 2'd2,
        K_AGED  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_EVAL,
        S_WRITE,
        S_FINISH
    } state_e;

    localparam logic [1:0] OP_INSERT = 2'd1;

endpackage

// File: rtl/tsearch_classify.sv
module tsearch_classify
    import tsearch_pkg::*;
(
    input  logic [KEY_W-1:0] entry,
    input  logic [MAC_W-1:0] key_mac,
    input  logic [VID_W-1:0] key_vid,
    output logic             addr_hit,
    output logic             vlan_hit,
    output logic             slot_free,
    output logic             slot_aged
);
    logic [1:0]       etype;
    logic [1:0]       ukind;
    logic [VID_W-1:0] evid;
    logic             is_addr;
    logic             vid_eq;

    always_comb begin
        etype     = entry[TYPE_LO +: 2];
        ukind     = entry[UKIND_LO +: 2];
        evid      = entry[VID_LO +: VID_W];
        is_addr   = (etype == 2'd1) || (etype == 2'd3);
        vid_eq    = (evid == key_vid);
        addr_hit  = is_addr && vid_eq && (entry[MAC_W-1:0] == key_mac);
        vlan_hit  = (etype == 2'd2) && vid_eq;
        slot_free = (etype == 2'd0);
        slot_aged = is_addr && !entry[MCAST_B] &&
                    ((ukind == 2'd1) || (ukind == 2'd3));
    end

endmodule

// File: rtl/tsearch_first_hit.sv
module tsearch_first_hit #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    output logic             seen_nxt,
    output logic [IDX_W-1:0] pos_nxt
);
    logic             seen_q;
    logic [IDX_W-1:0] pos_q;

    always_comb begin
        seen_nxt = seen_q;
        pos_nxt  = pos_q;
        if (sample && hit && !seen_q) begin
            seen_nxt = 1'b1;
            pos_nxt  = idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            pos_q  <= '0;
        end else if (clear) begin
            seen_q <= 1'b0;
            pos_q  <= '0;
        end else begin
            seen_q <= seen_nxt;
            pos_q  <= pos_nxt;
        end
    end

endmodule

// File: rtl/tsearch_engine.sv
module tsearch_engine
    import tsearch_pkg::*;
#(
    parameter  int ENTRY_W = 72,
    parameter  int DEPTH   = 16,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op,
    input  logic               use_vlan,
    input  logic [VID_W-1:0]   vid,
    input  logic [MAC_W-1:0]   mac,
    input  logic [ENTRY_W-1:0] new_entry,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic [IDX_W-1:0]   index,
    output logic [1:0]         kind,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_addr,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_addr,
    output logic [ENTRY_W-1:0] wr_data
);
    localparam int          NCAT     = 2;
    localparam int          CAT_FREE = 0;
    localparam int          CAT_AGED = 1;
    localparam [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);

    state_e             state_q, state_n;
    logic [IDX_W-1:0]   idx_q;
    logic [1:0]         req_op;
    logic [MAC_W-1:0]   req_mac;
    logic [VID_W-1:0]   req_vid;
    logic [ENTRY_W-1:0] req_entry;
    logic               res_found;
    logic [IDX_W-1:0]   res_idx;
    kind_e              res_kind;

    logic addr_hit, vlan_hit, slot_free, slot_aged;
    logic is_ins, is_vlan, key_hit, at_last;
    logic scan_clear, scan_sample;
    logic [NCAT-1:0]  cat_hit;
    logic [NCAT-1:0]  cat_seen;
    logic [IDX_W-1:0] cat_pos [NCAT];
    logic             unused_hi;

    assign unused_hi = ^rd_data[ENTRY_W-1:KEY_W];

    tsearch_classify u_cls (
        .entry     (rd_data[KEY_W-1:0]),
        .key_mac   (req_mac),
        .key_vid   (req_vid),
        .addr_hit  (addr_hit),
        .vlan_hit  (vlan_hit),
        .slot_free (slot_free),
        .slot_aged (slot_aged)
    );

    assign cat_hit[CAT_FREE] = slot_free;
    assign cat_hit[CAT_AGED] = slot_aged;

    generate
        for (genvar g = 0; g < NCAT; g++) begin : g_cat
            tsearch_first_hit #(.IDX_W(IDX_W)) u_first (
                .clk      (clk),
                .rst_n    (rst_n),
                .clear    (scan_clear),
                .sample   (scan_sample),
                .hit      (cat_hit[g]),
                .idx      (idx_q),
                .seen_nxt (cat_seen[g]),
                .pos_nxt  (cat_pos[g])
            );
        end
    endgenerate

    always_comb begin
        is_ins      = (req_op == OP_INSERT);
        is_vlan     = req_op[1];
        key_hit     = is_vlan ? vlan_hit : addr_hit;
        at_last     = (idx_q == LAST_IDX);
        scan_clear  = (state_q == S_IDLE) && start;
        scan_sample = (state_q == S_EVAL) && is_ins;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_n = S_FETCH;
            S_FETCH:  state_n = S_EVAL;
            S_EVAL: begin
                if (key_hit)
                    state_n = is_ins ? S_WRITE : S_FINISH;
                else if (at_last)
                    state_n = (is_ins && (cat_seen[CAT_FREE] || cat_seen[CAT_AGED]))
                              ? S_WRITE : S_FINISH;
                else
                    state_n = S_FETCH;
            end
            S_WRITE:  state_n = S_FINISH;
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            req_op    <= '0;
            req_mac   <= '0;
            req_vid   <= '0;
            req_entry <= '0;
            res_found <= 1'b0;
            res_idx   <= '0;
            res_kind  <= K_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        idx_q     <= '0;
                        req_op    <= op;
                        req_mac   <= mac;
                        req_vid   <= (use_vlan || op[1]) ? vid : '0;
                        req_entry <= new_entry;
                        res_found <= 1'b0;
                        res_idx   <= '0;
                        res_kind  <= K_NONE;
                    end
                end
                S_EVAL: begin
                    if (key_hit) begin
                        res_found <= 1'b1;
                        res_idx   <= idx_q;
                        res_kind  <= K_MATCH;
                    end else if (at_last) begin
                        if (is_ins && cat_seen[CAT_FREE]) begin
                            res_found <= 1'b1;
                            res_idx   <= cat_pos[CAT_FREE];
                            res_kind  <= K_FREE;
                        end else if (is_ins && cat_seen[CAT_AGED]) begin
                            res_found <= 1'b1;
                            res_idx   <= cat_pos[CAT_AGED];
                            res_kind  <= K_AGED;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != S_IDLE);
        done    = (state_q == S_FINISH);
        rd_en   = (state_q == S_FETCH);
        rd_addr = idx_q;
        wr_en   = (state_q == S_WRITE);
        wr_addr = res_idx;
        wr_data = req_entry;
        found   = res_found;
        index   = res_idx;
        kind    = res_kind;
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(found) && $stable(index) && $stable(kind)));

    assert_write_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (done && found));

    assert_fail_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> !$past(wr_en));

    assert_fetch_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    assert_kind_found_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (found == (kind != 2'd0)));

endmodule

// File: tb/tsearch_engine_test.sv
module tsearch_engine_test;
    localparam int ENTRY_W = 72;
    localparam int DEPTH   = 16;
    localparam int IDX_W   = 4;
    localparam int NVEC    = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         op = '0;
    logic               use_vlan = 1'b0;
    logic [11:0]        vid = '0;
    logic [47:0]        mac = '0;
    logic [ENTRY_W-1:0] new_entry = '0;
    logic               busy, done, found, rd_en, wr_en;
    logic [IDX_W-1:0]   index, rd_addr, wr_addr;
    logic [1:0]         kind;
    logic [ENTRY_W-1:0] rd_data, wr_data;

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [ENTRY_W-1:0] rd_q = '0;
    int                 wr_count = 0;
    int                 checks = 0;
    int                 fails = 0;

    always #5 clk = ~clk;

    tsearch_engine #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_vlan(use_vlan),
        .vid(vid), .mac(mac), .new_entry(new_entry), .busy(busy), .done(done),
        .found(found), .index(index), .kind(kind), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign rd_data = rd_q;

    always @(posedge clk) begin
        if (rd_en) rd_q <= mem[rd_addr];
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_count     <= wr_count + 1;
        end
    end

    function automatic logic [ENTRY_W-1:0] mk(input logic [1:0] et, input logic [1:0] uk,
                                              input logic [11:0] v, input logic [47:0] m);
        return {8'h00, uk, et, v, m};
    endfunction

    function automatic logic [47:0] macn(input int k);
        return 48'h0200_0000_0000 | 48'(k);
    endfunction

    task automatic chk(input string req, input logic [ENTRY_W-1:0] act, input logic [ENTRY_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one request; lat = edges from capture edge until done is seen.
    task automatic run(input logic [1:0] o, input logic uv, input logic [11:0] v,
                       input logic [47:0] m, input logic [ENTRY_W-1:0] ne, input bit poke,
                       output int lat, output logic f, output logic [IDX_W-1:0] ix,
                       output logic [1:0] kd);
        @(negedge clk);
        op = o; use_vlan = uv; vid = v; mac = m; new_entry = ne; start = 1'b1;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 1000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (poke && lat == 4) begin
                start = 1'b1; op = 2'd2; vid = 12'd9; mac = '1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        f = found; ix = index; kd = kind;
    endtask

    // {op, use_vlan, vid, mac, exp_found, exp_idx}
    localparam logic [67:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 12'd7,   48'h0200_0000_0001, 1'b1, 4'd0},
        {2'd0, 1'b1, 12'd5,   48'h0200_0000_0001, 1'b1, 4'd2},
        {2'd0, 1'b1, 12'd5,   48'h0200_0000_0005, 1'b0, 4'd0},
        {2'd0, 1'b1, 12'd6,   48'h0200_0000_0001, 1'b0, 4'd0},
        {2'd2, 1'b0, 12'd5,   48'h0,              1'b1, 4'd3},
        {2'd2, 1'b0, 12'd9,   48'h0,              1'b1, 4'd6},
        {2'd2, 1'b0, 12'd100, 48'h0,              1'b1, 4'd15},
        {2'd2, 1'b0, 12'd7,   48'h0,              1'b0, 4'd0},
        {2'd0, 1'b0, 12'd0,   48'h0200_0000_001E, 1'b1, 4'd14},
        {2'd0, 1'b1, 12'd0,   48'h0200_0000_0001, 1'b1, 4'd0},
        {2'd2, 1'b0, 12'd0,   48'h0,              1'b0, 4'd0},
        {2'd0, 1'b0, 12'd0,   48'h0200_0000_0009, 1'b0, 4'd0}
    };

    task automatic ins(input string req, input logic [47:0] m, input logic uv,
                       input logic [11:0] v, input logic [ENTRY_W-1:0] ne,
                       input logic ef, input int ei, input logic [1:0] ek, input int elat);
        int lat; logic f; logic [IDX_W-1:0] ix; logic [1:0] kd; int w0;
        w0 = wr_count;
        run(2'd1, uv, v, m, ne, 1'b0, lat, f, ix, kd);
        chk({req, " found"}, ENTRY_W'(f), ENTRY_W'(ef));
        chk({req, " kind"}, ENTRY_W'(kd), ENTRY_W'(ek));
        chk({req, " latency"}, ENTRY_W'(lat), ENTRY_W'(elat));
        if (ef) begin
            chk({req, " index"}, ENTRY_W'(ix), ENTRY_W'(ei));
            chk({req, " R7 table write"}, mem[ei], ne);
            chk({req, " R7 one write"}, ENTRY_W'(wr_count - w0), ENTRY_W'(1));
        end else begin
            chk({req, " R8 no write"}, ENTRY_W'(wr_count - w0), ENTRY_W'(0));
        end
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lat; logic f; logic [IDX_W-1:0] ix; logic [1:0] kd;
        for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd1, 2'd0, 12'd0, macn(16 + i));
        mem[0]  = mk(2'd1, 2'd0, 12'd0, macn(1));
        mem[1]  = '0;
        mem[2]  = mk(2'd3, 2'd0, 12'd5, macn(1));
        mem[3]  = mk(2'd2, 2'd0, 12'd5, macn(5));
        mem[4]  = mk(2'd1, 2'd1, 12'd0, macn(7));
        mem[5]  = mk(2'd1, 2'd3, 12'd0, 48'h0300_0000_0055);
        mem[6]  = mk(2'd2, 2'd0, 12'd9, 48'h0);
        mem[7]  = '0;
        mem[8]  = mk(2'd3, 2'd3, 12'd9, macn(9));
        mem[9]  = mk(2'd1, 2'd2, 12'd0, macn(25));
        mem[15] = mk(2'd2, 2'd0, 12'd100, 48'h0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", ENTRY_W'(busy), '0);
        chk("R1 done", ENTRY_W'(done), '0);
        chk("R1 wr_en", ENTRY_W'(wr_en), '0);
        chk("R1 rd_en", ENTRY_W'(rd_en), '0);
        chk("R1 found", ENTRY_W'(found), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: lookup vectors
        for (int n = 0; n < NVEC; n++) begin
            logic [67:0] vv;
            int elat;
            vv = VEC[n];
            run(vv[67:66], vv[65], vv[64:53], vv[52:5], '0, 1'b0, lat, f, ix, kd);
            elat = vv[4] ? (2 + 2 * int'(vv[3:0])) : 2 * DEPTH;
            chk($sformatf("R2/R4 vec%0d found", n), ENTRY_W'(f), ENTRY_W'(vv[4]));
            chk($sformatf("R5 vec%0d latency", n), ENTRY_W'(lat), ENTRY_W'(elat));
            chk($sformatf("R6 vec%0d kind", n), ENTRY_W'(kd), ENTRY_W'(vv[4] ? 2'd1 : 2'd0));
            if (vv[4]) chk($sformatf("R3/R5 vec%0d index", n), ENTRY_W'(ix), ENTRY_W'(vv[3:0]));
        end

        // R10: done lasts one cycle
        @(negedge clk);
        chk("R10 done pulse", ENTRY_W'(done), '0);

        // R9: second start during scan ignored
        run(2'd2, 1'b0, 12'd100, '0, '0, 1'b1, lat, f, ix, kd);
        chk("R9 index", ENTRY_W'(ix), ENTRY_W'(15));
        chk("R9 latency", ENTRY_W'(lat), ENTRY_W'(2 * DEPTH));

        // R6 R7 R8: inserts
        ins("R6 free1", macn(170), 1'b0, 12'd0, mk(2'd1, 2'd0, 12'd0, macn(170)), 1'b1, 1, 2'd2, 2 * DEPTH + 1);
        ins("R6 free7", macn(171), 1'b0, 12'd0, mk(2'd1, 2'd0, 12'd0, macn(171)), 1'b1, 7, 2'd2, 2 * DEPTH + 1);
        ins("R6 aged4", macn(172), 1'b0, 12'd0, mk(2'd1, 2'd0, 12'd0, macn(172)), 1'b1, 4, 2'd3, 2 * DEPTH + 1);
        ins("R6 aged8", macn(173), 1'b0, 12'd0, mk(2'd1, 2'd0, 12'd0, macn(173)), 1'b1, 8, 2'd3, 2 * DEPTH + 1);
        ins("R8 full", macn(174), 1'b0, 12'd0, mk(2'd1, 2'd0, 12'd0, macn(174)), 1'b0, 0, 2'd0, 2 * DEPTH);
        ins("R7 match2", macn(1), 1'b1, 12'd5, mk(2'd3, 2'd0, 12'd5, macn(1)) | (72'h3 << 66), 1'b1, 2, 2'd1, 7);
        ins("R7 match1", macn(170), 1'b0, 12'd33, mk(2'd1, 2'd0, 12'd0, macn(170)) | (72'h1 << 64), 1'b1, 1, 2'd1, 5);

        // R10: results held while idle
        repeat (5) @(negedge clk);
        chk("R10 hold found", ENTRY_W'(found), ENTRY_W'(1));
        chk("R10 hold index", ENTRY_W'(index), ENTRY_W'(1));
        chk("R10 hold kind", ENTRY_W'(kind), ENTRY_W'(1));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule